// File: doc/BRIEF.md
# Single-Frame Receive Buffer

This block sits between a receive MAC datapath and a host register port and parks exactly one received frame at a time. Frame bytes arrive one per cycle with start and end markers and per-beat error flags. When the end marker lands, the block latches a status word and raises a ready flag. That word holds the byte count, a general receive error and a checksum error. From then on, any frame that starts is thrown away and counted.

The host reads the status word and pulls the frame out through one fixed data address. Each read returns the next 32-bit word, with the earliest byte in the top lane. The host must drain every frame, including the ones it rejects. It then writes zero to the status address, which clears the flags, rewinds the read pointer and lets the next frame in. A level interrupt is high whenever a frame is waiting and the enable bit is set.

The buffer size is set by a parameter. The defaults hold 64 bytes, which is 16 words, and count up to 255 overflow frames.

Top module: `rx_frame_buf`

## Requirements
- R1: After reset the status word (address 0) is zero, the enable register (address 2) is zero, the overflow count (address 3) is zero and `irq` is low.
- R2: The status word is laid out as follows. Bit 31 is ready, bit 30 is the receive error, bit 29 is the checksum error, bits 15:0 are the frame length in bytes, and all other bits read zero. Ready is set in the cycle after the beat that carries the end marker.
- R3: Reading address 1 returns the word at the read pointer, and a read strobe on address 1 advances the pointer by one. Word k holds frame bytes 4k to 4k+3, with byte 4k in bits 31:24.
- R4: In the final word of a frame whose length is not a multiple of 4, only the top (length mod 4) byte lanes carry frame bytes.
- R5: The error flag is set when `in_err` was high on any beat of the frame. The checksum flag takes the value of `in_crc_err` on the end-marker beat.
- R6: Writing 0x00000000 to address 0 clears ready, both flags and the length, and rewinds the read pointer to word 0. The next frame is then accepted and read from word 0.
- R7: A write of any non-zero value to address 0 has no effect.
- R8: A frame that starts while ready is set is discarded whole, even if the release write arrives in the middle of it. The status and the stored data stay unchanged, and the overflow count rises by one.
- R9: `irq` equals ready AND bit 0 of the enable register, which is written and read at address 2.
- R10: Bytes beyond the buffer capacity are dropped. The length then reads as the capacity and the error flag is set.
- R11: A start marker that arrives before the end marker of the frame in progress restarts capture from byte 0.
- R12: The overflow count saturates at its maximum value (255 by default).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Byte beat valid |
| in_data | input | 8 | Received byte |
| in_sof | input | 1 | First byte of a frame |
| in_eof | input | 1 | Last byte of a frame |
| in_err | input | 1 | Receive error on this beat |
| in_crc_err | input | 1 | Checksum error, sampled on the end beat |
| reg_rd | input | 1 | Read strobe (pops the data port) |
| reg_wr | input | 1 | Write strobe |
| reg_addr | input | 2 | Register address: 0 status, 1 data, 2 enable, 3 overflow count |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| irq | output | 1 | Level receive-ready interrupt |

## Verification
The assertions take the following for granted:
- the capacity is a power of two, at least 4;
- the release write is the only way ready falls;
- a held frame's length and flags move only on release.

The stimulus keeps to that contract in three ways:
- Byte beats are driven between clock edges.
- A start marker always opens each frame.
- The host strobes touch one address per cycle.

Frames aimed at a full buffer, and releases issued mid-frame, are also applied, so the drop path runs under the same contract.

// File: rtl/rxfb_pkg.sv
package rxfb_pkg;
  localparam logic [1:0] ADR_STAT = 2'd0;
  localparam logic [1:0] ADR_DATA = 2'd1;
  localparam logic [1:0] ADR_IEN  = 2'd2;
  localparam logic [1:0] ADR_OVF  = 2'd3;
  localparam int STAT_RDY_BIT = 31;
  localparam int STAT_ERR_BIT = 30;
  localparam int STAT_CRC_BIT = 29;
endpackage

// File: rtl/rxfb_capture.sv
module rxfb_capture #(
  parameter  int BYTES  = 64,
  parameter  int OVF_W  = 8,
  localparam int IDX_W  = $clog2(BYTES),
  localparam int WIDX_W = IDX_W - 2,
  localparam int LEN_W  = $clog2(BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  input  logic              in_sof,
  input  logic              in_eof,
  input  logic              in_err,
  input  logic              in_crc_err,
  input  logic              release_i,
  input  logic [WIDX_W-1:0] rd_idx,
  output logic [31:0]       rd_word,
  output logic              ready,
  output logic              err_flag,
  output logic              crc_flag,
  output logic [LEN_W-1:0]  len,
  output logic [OVF_W-1:0]  ovf_cnt
);
  logic [7:0]       mem_q [BYTES];
  logic [LEN_W-1:0] cnt_q, cnt_d, idx, len_q, len_d;
  logic             active_q, active_d, acc_q, acc_d;
  logic             ready_q, ready_d, err_q, err_d, crc_q, crc_d;
  logic [OVF_W-1:0] ovf_q, ovf_d;
  logic             take, room, wr_en, done;

  always_comb begin
    take     = in_valid && !ready_q && (in_sof || active_q);
    idx      = in_sof ? '0 : cnt_q;
    room     = idx < LEN_W'(BYTES);
    wr_en    = take && room;
    done     = take && in_eof;
    cnt_d    = cnt_q;
    acc_d    = acc_q;
    active_d = active_q;
    if (take) begin
      cnt_d    = room ? idx + LEN_W'(1) : idx;
      acc_d    = (in_sof ? 1'b0 : acc_q) | in_err | !room;
      active_d = !in_eof;
    end
    ready_d = ready_q;
    len_d   = len_q;
    err_d   = err_q;
    crc_d   = crc_q;
    if (done) begin
      ready_d = 1'b1;
      len_d   = cnt_d;
      err_d   = acc_d;
      crc_d   = in_crc_err;
    end else if (release_i) begin
      ready_d = 1'b0;
      len_d   = '0;
      err_d   = 1'b0;
      crc_d   = 1'b0;
    end
    ovf_d = ovf_q;
    if (in_valid && in_sof && ready_q && (ovf_q != {OVF_W{1'b1}}))
      ovf_d = ovf_q + OVF_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      active_q <= 1'b0;
      acc_q    <= 1'b0;
      ready_q  <= 1'b0;
      len_q    <= '0;
      err_q    <= 1'b0;
      crc_q    <= 1'b0;
      ovf_q    <= '0;
    end else begin
      cnt_q    <= cnt_d;
      active_q <= active_d;
      acc_q    <= acc_d;
      ready_q  <= ready_d;
      len_q    <= len_d;
      err_q    <= err_d;
      crc_q    <= crc_d;
      ovf_q    <= ovf_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[idx[IDX_W-1:0]] <= in_data;
  end

  always_comb begin
    for (int l = 0; l < 4; l++)
      rd_word[31-8*l -: 8] = mem_q[{rd_idx, 2'(l)}];
  end

  assign ready    = ready_q;
  assign err_flag = err_q;
  assign crc_flag = crc_q;
  assign len      = len_q;
  assign ovf_cnt  = ovf_q;

  // R6
  ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready_q && !release_i |=> ready_q);
  // R6
  ready_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ready_q) |-> $past(release_i));
  // R8
  status_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready_q && !release_i |=> $stable(len_q) && $stable(err_q) && $stable(crc_q));
  // R12
  ovf_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q == {OVF_W{1'b1}} |=> ovf_q == {OVF_W{1'b1}});
  // R10
  always_comb begin
    if (rst_n) len_bound_chk: assert (len_q <= LEN_W'(BYTES));
  end
endmodule

// File: rtl/rxfb_host.sv
module rxfb_host
  import rxfb_pkg::*;
#(
  parameter int WIDX_W = 4,
  parameter int LEN_W  = 7,
  parameter int OVF_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_rd,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              ready,
  input  logic              err_flag,
  input  logic              crc_flag,
  input  logic [LEN_W-1:0]  len,
  input  logic [OVF_W-1:0]  ovf_cnt,
  input  logic [31:0]       rd_word,
  output logic [WIDX_W-1:0] rd_idx,
  output logic              release_o,
  output logic              irq
);
  logic [WIDX_W-1:0] rptr_q, rptr_d;
  logic              ien_q, ien_d;
  logic              pop;

  always_comb begin
    release_o = reg_wr && (reg_addr == ADR_STAT) && (reg_wdata == 32'd0);
    pop       = reg_rd && (reg_addr == ADR_DATA);
    rptr_d    = rptr_q;
    if (release_o)  rptr_d = '0;
    else if (pop)   rptr_d = rptr_q + WIDX_W'(1);
    ien_d = ien_q;
    if (reg_wr && (reg_addr == ADR_IEN)) ien_d = reg_wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rptr_q <= '0;
      ien_q  <= 1'b0;
    end else begin
      rptr_q <= rptr_d;
      ien_q  <= ien_d;
    end
  end

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      ADR_STAT: begin
        reg_rdata[STAT_RDY_BIT] = ready;
        reg_rdata[STAT_ERR_BIT] = err_flag;
        reg_rdata[STAT_CRC_BIT] = crc_flag;
        reg_rdata[15:0]         = 16'(len);
      end
      ADR_DATA: reg_rdata = rd_word;
      ADR_IEN:  reg_rdata[0] = ien_q;
      default:  reg_rdata = 32'(ovf_cnt);
    endcase
  end

  assign rd_idx = rptr_q;
  assign irq    = ready & ien_q;

  // R6
  rptr_rewind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    release_o |=> rptr_q == '0);
  // R3
  rptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop && !release_o |=> rptr_q == $past(rptr_q) + WIDX_W'(1));
endmodule

// File: rtl/rx_frame_buf.sv
module rx_frame_buf #(
  parameter  int BYTES  = 64,
  parameter  int OVF_W  = 8,
  localparam int WIDX_W = $clog2(BYTES) - 2,
  localparam int LEN_W  = $clog2(BYTES + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [7:0]  in_data,
  input  logic        in_sof,
  input  logic        in_eof,
  input  logic        in_err,
  input  logic        in_crc_err,
  input  logic        reg_rd,
  input  logic        reg_wr,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        irq
);
  logic [WIDX_W-1:0] rd_idx;
  logic [31:0]       rd_word;
  logic              ready, err_flag, crc_flag, release_s;
  logic [LEN_W-1:0]  len;
  logic [OVF_W-1:0]  ovf_cnt;

  rxfb_capture #(.BYTES(BYTES), .OVF_W(OVF_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_sof(in_sof), .in_eof(in_eof), .in_err(in_err), .in_crc_err(in_crc_err),
    .release_i(release_s), .rd_idx(rd_idx), .rd_word(rd_word),
    .ready(ready), .err_flag(err_flag), .crc_flag(crc_flag),
    .len(len), .ovf_cnt(ovf_cnt)
  );

  rxfb_host #(.WIDX_W(WIDX_W), .LEN_W(LEN_W), .OVF_W(OVF_W)) u_host (
    .clk(clk), .rst_n(rst_n), .reg_rd(reg_rd), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ready(ready), .err_flag(err_flag), .crc_flag(crc_flag), .len(len),
    .ovf_cnt(ovf_cnt), .rd_word(rd_word), .rd_idx(rd_idx),
    .release_o(release_s), .irq(irq)
  );
endmodule

// File: tb/tb_rx_frame_buf.sv
`timescale 1ns/1ps
module tb_rx_frame_buf;
  localparam int CAP = 64;
  // {len[23:16], seed[15:8], err[1], crc[0]}
  localparam logic [23:0] VEC [0:7] = '{
    24'h010500, 24'h041100, 24'h052202, 24'h073301,
    24'h084403, 24'h3C5500, 24'h406600, 24'h467700 };

  logic clk = 1'b0;
  logic rst_n;
  logic in_valid, in_sof, in_eof, in_err, in_crc_err;
  logic [7:0] in_data;
  logic reg_rd, reg_wr;
  logic [1:0] reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic irq;
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  rx_frame_buf dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_sof(in_sof), .in_eof(in_eof), .in_err(in_err), .in_crc_err(in_crc_err),
    .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  function automatic logic [7:0] bval(int seed, int i);
    return 8'((seed + i * 7) & 255);
  endfunction

  function automatic logic [31:0] stat_exp(bit r, bit e, bit c, int n);
    return {r, e, c, 13'd0, 16'(n)};
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic beat(bit v, bit s, bit e, logic [7:0] d, bit er, bit c);
    @(negedge clk);
    in_valid = v; in_sof = s; in_eof = e; in_data = d; in_err = er; in_crc_err = c;
  endtask

  // sends n bytes; err on beat n/2, crc on last beat; set eof=0 to leave open
  task automatic send(int n, int seed, bit er, bit c, bit close = 1);
    for (int i = 0; i < n; i++)
      beat(1'b1, i == 0, close && (i == n - 1), bval(seed, i),
           er && (i == n / 2), c && (i == n - 1));
    beat(1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0);
  endtask

  task automatic rd_reg(logic [1:0] a, output logic [31:0] v);
    @(negedge clk);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  task automatic pop(output logic [31:0] v);
    @(negedge clk);
    reg_addr = 2'd1;
    #1 v = reg_rdata;
    reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic wr_reg(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic check_words(string tag, int n, int seed);
    logic [31:0] w, exp, msk;
    for (int k = 0; k < (n + 3) / 4; k++) begin
      pop(w);
      exp = '0; msk = '0;
      for (int l = 0; l < 4; l++)
        if (4 * k + l < n) begin
          exp[31-8*l -: 8] = bval(seed, 4 * k + l);
          msk[31-8*l -: 8] = 8'hFF;
        end
      check(tag, w & msk, exp);
    end
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int n, sd, ov;
    bit e, c;
    rst_n = 1'b0; in_valid = 0; in_sof = 0; in_eof = 0; in_err = 0; in_crc_err = 0;
    in_data = 0; reg_rd = 0; reg_wr = 0; reg_addr = 0; reg_wdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd_reg(2'd0, v); check("R1 status", v, 32'd0);
    rd_reg(2'd2, v); check("R1 enable", v, 32'd0);
    rd_reg(2'd3, v); check("R1 overflow", v, 32'd0);
    check("R1 irq", {31'd0, irq}, 32'd0);

    // R9 masked interrupt, then enable
    send(6, 3, 0, 0);
    check("R9 irq masked", {31'd0, irq}, 32'd0);
    wr_reg(2'd2, 32'h1);
    rd_reg(2'd2, v); check("R9 enable readback", v, 32'd1);
    check("R9 irq on", {31'd0, irq}, 32'd1);
    check_words("R3 drain", 6, 3);
    wr_reg(2'd0, 32'd0);

    // table walk: R2 R3 R4 R5 R10 R6
    for (int t = 0; t < 8; t++) begin
      n = int'(VEC[t][23:16]); sd = int'(VEC[t][15:8]);
      e = VEC[t][1]; c = VEC[t][0];
      send(n, sd, e, c);
      rd_reg(2'd0, v);
      check("R2 R5 R10 status", v,
            stat_exp(1, e || (n > CAP), c, (n > CAP) ? CAP : n));
      check("R9 irq", {31'd0, irq}, 32'd1);
      check_words("R3 R4 data", (n > CAP) ? CAP : n, sd);
      wr_reg(2'd0, 32'd0);
      rd_reg(2'd0, v); check("R6 released", v, 32'd0);
      check("R9 irq low", {31'd0, irq}, 32'd0);
    end

    // R7 non-zero write ignored
    send(9, 20, 0, 1);
    wr_reg(2'd0, 32'h8000_0000);
    rd_reg(2'd0, v); check("R7 status kept", v, stat_exp(1, 0, 1, 9));
    // R8 overflow: second frame dropped
    send(12, 90, 1, 0);
    rd_reg(2'd0, v); check("R8 status kept", v, stat_exp(1, 0, 1, 9));
    rd_reg(2'd3, v); check("R8 overflow count", v, 32'd1);
    pop(v); check("R8 data kept", v, {bval(20,0), bval(20,1), bval(20,2), bval(20,3)});
    // R6 release mid-read, new frame reads from word 0
    wr_reg(2'd0, 32'd0);
    send(5, 40, 0, 0);
    check_words("R6 restart", 5, 40);
    // R8 release inside a dropped frame: remainder ignored
    in_valid = 0;
    beat(1, 1, 0, 8'hAA, 0, 0);
    beat(1, 0, 0, 8'hBB, 0, 0);
    beat(0, 0, 0, 8'h00, 0, 0);
    wr_reg(2'd0, 32'd0);
    beat(1, 0, 0, 8'hCC, 0, 0);
    beat(1, 0, 1, 8'hDD, 0, 0);
    beat(0, 0, 0, 8'h00, 0, 0);
    rd_reg(2'd0, v); check("R8 tail ignored", v, 32'd0);
    rd_reg(2'd3, v); check("R8 overflow count 2", v, 32'd2);

    // R11 restart on early start marker
    send(3, 70, 1, 0, 0);
    send(5, 80, 0, 0);
    rd_reg(2'd0, v); check("R11 status", v, stat_exp(1, 0, 0, 5));
    check_words("R11 data", 5, 80);

    // R12 saturation of overflow count (buffer still full)
    for (int i = 0; i < 300; i++) beat(1, 1, 1, 8'h11, 0, 0);
    beat(0, 0, 0, 8'h00, 0, 0);
    rd_reg(2'd3, v); check("R12 saturated", v, 32'd255);
    rd_reg(2'd0, v); check("R12 status kept", v, stat_exp(1, 0, 0, 5));
    wr_reg(2'd0, 32'd0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule